// File: doc/BRIEF.md
# Bank-Switched RAM Overlay Switch Controller

This block decides how a bank-switched RAM card that overlays a ROM region answers the bus. A group of sixteen I/O addresses acts as soft switches. Every bus cycle that touches one of them sets three controls. The first chooses whether the overlay region is read from RAM or from ROM. The second chooses which of two 4 KB banks backs the lowest window of the region. The third says whether stores into the region land in RAM.

Writing into RAM is protected by an arming sequence. The bus must make two back-to-back read cycles to switch addresses that carry the arming bit. Only then does RAM write enable turn on. A processor store that reads its target before writing it supplies one of those reads. Any other switch access in between restarts the sequence. The RAM array and the ROM sit outside the block. It only drives their decode controls.

Top module: `lcsw_ctrl`

## Requirements
- R1: While reset is low and after it, the outputs are: ROM read selected (`ram_rd_sel`=0), bank 2 selected (`bank1_sel`=0), RAM writes disabled (`ram_wr_en`=0). The arming count is zero.
- R2: A strobed access (read or write) to a switch address sets `ram_rd_sel` to 1 when address bits [1:0] are 00 or 11, and to 0 when they are 01 or 10. The new value is visible the cycle after the strobe.
- R3: A strobed switch access sets `bank1_sel` to the value of address bit 3 (1 = bank 1, 0 = bank 2), the cycle after the strobe.
- R4: A strobed switch access with address bit 0 clear (read or write) forces `ram_wr_en` to 0 and clears the arming count.
- R5: Two consecutive strobed reads to switch addresses with bit 0 set turn `ram_wr_en` on after the second read. A single such read leaves it off. The two addresses may differ.
- R6: A strobed write to a switch address with bit 0 set clears the arming count and leaves `ram_wr_en` unchanged. So read, write, read does not enable writes.
- R7: A store that performs a read and then a write to an arming switch address counts as a read. One read followed by such a store enables writes.
- R8: Cycles with the strobe low, and strobed accesses outside the sixteen-address window (base `SW_BASE`), change no output and do not disturb the arming count.
- R9: An access to the base switch address (low nibble 0) selects bank 2, RAM read and write disable together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Address of the current bus cycle |
| bus_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_strobe | input | 1 | High for one clock per valid bus cycle |
| ram_rd_sel | output | 1 | 1 = overlay reads come from RAM, 0 = from ROM |
| ram_wr_en | output | 1 | 1 = stores to the overlay are written to RAM |
| bank1_sel | output | 1 | 1 = bank 1 backs the lowest window, 0 = bank 2 |

## Verification
The arming count is the only state that never reaches a port directly. A count that is stuck, saturates wrongly or is not cleared only shows when `ram_wr_en` moves. This happens one cycle after a later arming read, and it can look correct until then. For that reason the bench sweeps every ordered pair of switch accesses from reset, in both directions. This covers 32 by 32 combinations and exposes a wrong count by the second access. A wrong read-source or bank register shows at the port in the very next cycle.

// File: rtl/lcsw_pkg.sv
// Package: shared types for the overlay soft-switch controller.
// Assumes one bus cycle per strobe; fields are decoded from the low nibble.
package lcsw_pkg;

    // One decoded bus access, as seen by the state-holding submodules.
    typedef struct packed {
        logic hit;      // strobed access inside the switch window
        logic rnw;      // 1 = read cycle
        logic ram_rd;   // requested read source is RAM
        logic bank1;    // requested bank for the lowest window
        logic arm_sel;  // address carries the write-arming bit
    } lcsw_access_t;

endpackage

// File: rtl/lcsw_decode.sv
// Module: lcsw_decode
// Matches the bus address against the sixteen-address switch window and
// splits the low nibble into its fields. Purely combinational.
// Assumes SW_BASE is aligned to the window size.
module lcsw_decode
    import lcsw_pkg::*;
#(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rnw,
    input  logic              bus_strobe,
    output lcsw_access_t      acc
);
    localparam int SEL_W = 4;
    localparam int TAG_W = ADDR_W - SEL_W;
    localparam logic [TAG_W-1:0] BASE_TAG = SW_BASE[ADDR_W-1:SEL_W];

    logic [SEL_W-1:0] sel;

    // Field extraction and window match for the current cycle.
    always_comb begin
        sel         = bus_addr[SEL_W-1:0];
        acc.hit     = bus_strobe && (bus_addr[ADDR_W-1:SEL_W] == BASE_TAG);
        acc.rnw     = bus_rnw;
        acc.ram_rd  = ~(sel[1] ^ sel[0]);
        acc.bank1   = sel[3];
        acc.arm_sel = sel[0];
    end
endmodule

// File: rtl/lcsw_arm.sv
// Module: lcsw_arm
// Pre-write counter and RAM write enable. Reads to arming switches count up
// (saturating); ARM_READS consecutive ones set the enable. Writes to arming
// switches restart the count; non-arming switches disable and restart.
// Assumes acc is already qualified by the strobe and the window.
module lcsw_arm
    import lcsw_pkg::*;
#(
    parameter int ARM_READS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  lcsw_access_t acc,
    output logic         wr_en
);
    localparam int CNT_W = $clog2(ARM_READS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ARM_READS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(ARM_READS);

    logic [CNT_W-1:0] cnt;

    // Advance, restart or hold the arming sequence on each switch access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            wr_en <= 1'b0;
        end else if (acc.hit) begin
            if (!acc.arm_sel) begin
                cnt   <= '0;
                wr_en <= 1'b0;
            end else if (acc.rnw) begin
                if (cnt >= CNT_LAST) wr_en <= 1'b1;
                if (cnt != CNT_MAX)  cnt   <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    // R5: enable only ever rises right after an arming read
    a_r5_rise_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(acc.hit && acc.rnw && acc.arm_sel));

    // R5: a lone arming read from a fresh count does not enable
    a_r5_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ARM_READS > 1 && acc.hit && acc.rnw && acc.arm_sel && cnt == '0 && !wr_en)
        |=> !wr_en);

    // R4: non-arming switch access disables writes
    a_r4_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.hit && !acc.arm_sel) |=> (!wr_en && cnt == '0));

    // R6: write to arming switch leaves enable alone and restarts the count
    a_r6_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.hit && acc.arm_sel && !acc.rnw) |=> ($stable(wr_en) && cnt == '0));

    // R8: idle cycles touch neither count nor enable
    a_r8_arm_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc.hit |=> ($stable(cnt) && $stable(wr_en)));
endmodule

// File: rtl/lcsw_mode.sv
// Module: lcsw_mode
// Holds the read-source and bank selections; every switch access, read or
// write, loads both from the decoded address. Assumes qualified acc.
module lcsw_mode
    import lcsw_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  lcsw_access_t acc,
    output logic         ram_rd,
    output logic         bank1
);
    // Load read source and bank on any switch access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_rd <= 1'b0;
            bank1  <= 1'b0;
        end else if (acc.hit) begin
            ram_rd <= acc.ram_rd;
            bank1  <= acc.bank1;
        end
    end

    // R1: reset state is ROM read, bank 2
    a_r1_reset_mode: assert property (@(posedge clk)
        !rst_n |=> (!ram_rd && !bank1));

    // R8: selections hold when no switch is touched
    a_r8_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc.hit |=> ($stable(ram_rd) && $stable(bank1)));
endmodule

// File: rtl/lcsw_ctrl.sv
// Module: lcsw_ctrl (top)
// Soft-switch controller for a RAM card overlaying ROM: decodes switch
// accesses and drives read source, bank select and RAM write enable.
// Outputs are registered and change the cycle after a strobed access.
// Assumes one strobe per bus cycle; a read-modify store appears as a read
// strobe followed by a write strobe.
module lcsw_ctrl
    import lcsw_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] SW_BASE   = 16'hC080,
    parameter int                ARM_READS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rnw,
    input  logic              bus_strobe,
    output logic              ram_rd_sel,
    output logic              ram_wr_en,
    output logic              bank1_sel
);
    lcsw_access_t acc;

    lcsw_decode #(.ADDR_W(ADDR_W), .SW_BASE(SW_BASE)) u_decode (
        .bus_addr   (bus_addr),
        .bus_rnw    (bus_rnw),
        .bus_strobe (bus_strobe),
        .acc        (acc)
    );

    lcsw_arm #(.ARM_READS(ARM_READS)) u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .wr_en (ram_wr_en)
    );

    lcsw_mode u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .ram_rd (ram_rd_sel),
        .bank1  (bank1_sel)
    );

    // R9: base switch gives RAM read, bank 2, writes off
    a_r9_base_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_addr == SW_BASE) |=> (ram_rd_sel && !bank1_sel && !ram_wr_en));

    // R1: reset leaves writes disabled
    a_r1_reset_wr: assert property (@(posedge clk)
        !rst_n |=> !ram_wr_en);
endmodule

// File: tb/lcsw_ctrl_test.sv
module lcsw_ctrl_test;
    localparam logic [15:0] BASE = 16'hC080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rnw = 1'b1;
    logic        bus_strobe = 1'b0;
    logic        ram_rd_sel, ram_wr_en, bank1_sel;

    int total = 0;
    int bad = 0;

    // expected state built from the requirements
    logic m_rd, m_bk1, m_we;
    int   m_cnt;

    always #10 clk = ~clk;

    lcsw_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
        .bus_strobe(bus_strobe), .ram_rd_sel(ram_rd_sel),
        .ram_wr_en(ram_wr_en), .bank1_sel(bank1_sel)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b time=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string ctx);
        chk({"R2 read source ", ctx}, ram_rd_sel, m_rd);
        chk({"R3 bank ", ctx}, bank1_sel, m_bk1);
        chk({"R5 write enable ", ctx}, ram_wr_en, m_we);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_strobe = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_rd = 0; m_bk1 = 0; m_we = 0; m_cnt = 0;
    endtask

    // one bus cycle; model applies R2..R8; outputs valid at the next negedge
    task automatic access(input logic [15:0] a, input logic rnw);
        @(negedge clk);
        bus_addr = a;
        bus_rnw = rnw;
        bus_strobe = 1'b1;
        @(negedge clk);
        bus_strobe = 1'b0;
        if (a[15:4] == BASE[15:4]) begin
            m_rd  = (a[1] == a[0]);
            m_bk1 = a[3];
            if (!a[0]) begin
                m_we = 0; m_cnt = 0;
            end else if (rnw) begin
                m_cnt = (m_cnt >= 2) ? 2 : m_cnt + 1;
                if (m_cnt >= 2) m_we = 1;
            end else begin
                m_cnt = 0;
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        chk("R1 rd during reset", ram_rd_sel, 1'b0);
        chk("R1 bank during reset", bank1_sel, 1'b0);
        chk("R1 we during reset", ram_wr_en, 1'b0);
        do_reset();
        @(negedge clk);
        chk("R1 rd after reset", ram_rd_sel, 1'b0);
        chk("R1 we after reset", ram_wr_en, 1'b0);

        // R5: one read not enough, second enables
        access(BASE | 16'h1, 1'b1);
        chk("R5 single read", ram_wr_en, 1'b0);
        access(BASE | 16'h3, 1'b1);
        chk("R5 second read", ram_wr_en, 1'b1);

        // R6: read, write, read does not enable; odd write keeps enable
        do_reset();
        access(BASE | 16'h3, 1'b1);
        access(BASE | 16'h3, 1'b0);
        access(BASE | 16'h3, 1'b1);
        chk("R6 broken sequence", ram_wr_en, 1'b0);
        access(BASE | 16'h3, 1'b1);
        chk("R6 rearmed", ram_wr_en, 1'b1);
        access(BASE | 16'h1, 1'b0);
        chk("R6 odd write keeps enable", ram_wr_en, 1'b1);
        chk("R6 odd write sets rom", ram_rd_sel, 1'b0);

        // R7: read, then a store (read then write)
        do_reset();
        access(BASE | 16'hB, 1'b1);
        access(BASE | 16'hB, 1'b1);
        access(BASE | 16'hB, 1'b0);
        chk("R7 store arms", ram_wr_en, 1'b1);
        chk("R7 bank1", bank1_sel, 1'b1);

        // R4: even write disables
        access(BASE | 16'h2, 1'b0);
        chk("R4 even write disables", ram_wr_en, 1'b0);
        chk("R4 bank2", bank1_sel, 1'b0);

        // R8: outside window and idle cycles change nothing, keep count
        do_reset();
        access(BASE | 16'h9, 1'b1);
        access(16'hC091, 1'b1);
        access(16'hC07F, 1'b0);
        access(16'h4089, 1'b1);
        chk("R8 outside keeps rd", ram_rd_sel, 1'b0);
        chk("R8 outside keeps bank", bank1_sel, 1'b1);
        chk("R8 outside keeps we", ram_wr_en, 1'b0);
        @(negedge clk);
        bus_addr = BASE; bus_rnw = 1'b1;   // strobe stays low
        @(negedge clk);
        @(negedge clk);
        chk("R8 no strobe keeps bank", bank1_sel, 1'b1);
        access(BASE | 16'hB, 1'b1);
        chk("R8 count survived", ram_wr_en, 1'b1);

        // R9: base address after bank1 + write enable
        access(BASE, 1'b1);
        chk("R9 bank2", bank1_sel, 1'b0);
        chk("R9 we off", ram_wr_en, 1'b0);
        chk("R9 ram read", ram_rd_sel, 1'b1);

        // sweep: every ordered pair of switch accesses from reset (R2..R7)
        for (int p = 0; p < 32; p++) begin
            for (int q = 0; q < 32; q++) begin
                do_reset();
                access(BASE | 16'(p & 15), logic'(p >> 4));
                check_all("first");
                access(BASE | 16'(q & 15), logic'(q >> 4));
                check_all("second");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule